// File: doc/BRIEF.md
# Pseudo-random clock-enable pulse skipper

This block sits in the clock-enable path of two clock domains, a main top clock and a crypto-engine clock, and removes some of the enable pulses it is handed. Which pulses disappear is decided by a 32-bit linear-feedback shift register per channel. Skipped pulses make the timing of a computation harder to correlate with its data, so power and timing side channels are harder to read. Dropping pulses only stretches execution; it never alters what the downstream logic computes.

Software programs the block through a small write-only port. A control word holds a 4-bit keep level and an enable bit for each channel. A higher level keeps more pulses: 0xF keeps all of them and 0x0 keeps roughly one in sixteen. The output never stops, because a run of dropped pulses is capped. A 32-bit seed is first written to a staging register. It only reaches the shift registers when the activation key is written to a separate address.

Top module: `clk_cipher_gate`

## Requirements
- R1: Synchronous active-low reset. After reset both channels are disabled, both levels are 0, the staging seed is 0, the drop-run counters are 0, and the channel-0 register holds 0x1D872B41 while the channel-1 register holds the same word with its 16-bit halves swapped (0x2B411D87).
- R2: A disabled channel passes its upstream enable to its output unchanged, in the same cycle.
- R3: The control word is written at address 0. Channel 0 (top clock) takes its level from bits [3:0] and its enable from bit [4]. Channel 1 (crypto clock) takes its level from bits [11:8] and its enable from bit [12]. A new control word takes effect on the cycle after the write.
- R4: On an enabled channel, a high upstream enable is kept when bits [31:28] of that channel's register are less than or equal to the level, and otherwise dropped, unless R6 forces it. The decision is combinational in the same cycle.
- R5: Level 0xF on an enabled channel keeps every upstream pulse.
- R6: An enabled channel never drops more than 15 consecutive upstream pulses. When 15 have been dropped, the next high upstream enable is kept. A kept pulse, a disabled channel or a seed activation clears the run count.
- R7: The register of an enabled channel advances once per cycle in which its upstream enable is high. The next state is the word shifted left by one, with bit 0 taking bit31 ^ bit21 ^ bit1 ^ bit0. A disabled channel's register holds its value.
- R8: A write to address 1 updates only the staging seed. The shift registers are loaded from the staging seed only by a write of exactly 0x0000005A to address 2, effective at the next cycle. Channel 0 takes the seed as written and channel 1 takes it with its halves swapped. Any other value written to address 2 has no effect.
- R9: Activation with a zero staging seed loads 0x1D872B41 in its place, halves swapped for channel 1.
- R10: An output enable is never high while its upstream enable is low.
- R11: The two channels are independent: the settings, input and state of one never affect the other's output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock of the block and of both enable streams |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Write address: 0 control, 1 staging seed, 2 activation |
| cfg_wdata | input | 32 | Write data |
| top_en_i | input | 1 | Upstream enable for the top clock |
| crypto_en_i | input | 1 | Upstream enable for the crypto clock |
| top_en_o | output | 1 | Scrambled enable for the top clock |
| crypto_en_o | output | 1 | Scrambled enable for the crypto clock |

## Verification
The bench sweeps all sixteen levels on both channels at once and holds a cycle-exact software copy of both shift registers and run counters, so a wrong tap, a wrong comparison direction or an off-by-one level shows up as a differing pulse. Level 0 forces runs of fifteen drops: a cap that is missing would let the output starve, and a cap set one short would keep pulses the copy drops. The seed sequence writes a seed without activating it, then sends near-miss keys and then the true key. A design that loads early, matches only the low byte or forgets the zero substitution follows a different pulse pattern from that point on. Random upstream patterns with one channel disabled catch a bypass that is not transparent and any coupling between the channels.

// File: rtl/ccip_pkg.sv
// Shared constants, types and helpers of the clock-cipher pulse skipper.
// Assumes exactly two channels whose control fields sit one byte apart.
package ccip_pkg;

    localparam int LFSR_W  = 32;
    localparam int LVL_W   = 4;
    localparam int NCH     = 2;
    localparam int FIELD_STRIDE = 8;
    localparam int ADDR_W  = 2;

    localparam logic [LFSR_W-1:0] ACT_KEY       = 32'h0000_005A;
    localparam logic [LFSR_W-1:0] SEED_FALLBACK = 32'h1D87_2B41;

    typedef enum logic [ADDR_W-1:0] {
        ADR_CTRL = 2'd0,
        ADR_SEED = 2'd1,
        ADR_ARM  = 2'd2,
        ADR_RSVD = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic             on;
        logic [LVL_W-1:0] level;
    } chan_cfg_t;

    // One shift of the maximal-length register (taps 32, 22, 2, 1).
    function automatic logic [LFSR_W-1:0] lfsr_next(input logic [LFSR_W-1:0] s);
        return {s[LFSR_W-2:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
    endfunction

    // Per-channel view of a seed: odd channels see the halves swapped.
    function automatic logic [LFSR_W-1:0] chan_seed(input logic [LFSR_W-1:0] v,
                                                    input int idx);
        if (idx % 2 == 1)
            return {v[LFSR_W/2-1:0], v[LFSR_W-1:LFSR_W/2]};
        return v;
    endfunction

endpackage

// File: rtl/ccip_regs.sv
// Write-only register bank: control word, staging seed and activation key.
// Assumes a single write port; the activation pulse is combinational so the
// shift registers load on the same edge that completes the key write.
module ccip_regs
    import ccip_pkg::*;
#(
    parameter logic [LFSR_W-1:0] FALLBACK = SEED_FALLBACK
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [LFSR_W-1:0]       wr_data,
    output chan_cfg_t [NCH-1:0]     cfg_o,
    output logic                    seed_load_o,
    output logic [LFSR_W-1:0]       seed_val_o
);

    logic [LFSR_W-1:0] seed_q;
    logic              ctrl_wr;
    logic              seed_wr;

    // Decode the write strobes.
    always_comb begin
        ctrl_wr     = wr_en && (wr_addr == ADR_CTRL);
        seed_wr     = wr_en && (wr_addr == ADR_SEED);
        seed_load_o = wr_en && (wr_addr == ADR_ARM) && (wr_data == ACT_KEY);
    end

    // Staging seed register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            seed_q <= '0;
        else if (seed_wr)
            seed_q <= wr_data;
    end

    // Substitute the fallback constant for an all-zero seed.
    always_comb seed_val_o = (seed_q == '0) ? FALLBACK : seed_q;

    // One control field per channel, one byte apart.
    for (genvar i = 0; i < NCH; i++) begin : g_field
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg_o[i] <= '0;
            end else if (ctrl_wr) begin
                cfg_o[i].level <= wr_data[FIELD_STRIDE*i +: LVL_W];
                cfg_o[i].on    <= wr_data[FIELD_STRIDE*i + LVL_W];
            end
        end
    end

endmodule

// File: rtl/ccip_lfsr.sv
// 32-bit Fibonacci shift register of one channel. Load has priority over
// step. Assumes the load value is already nonzero.
module ccip_lfsr
    import ccip_pkg::*;
#(
    parameter int                IDX      = 0,
    parameter logic [LFSR_W-1:0] FALLBACK = SEED_FALLBACK
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [LFSR_W-1:0] load_val_i,
    input  logic              step_i,
    output logic [LFSR_W-1:0] state_o
);

    localparam logic [LFSR_W-1:0] RESET_STATE = chan_seed(FALLBACK, IDX);

    // Load, advance or hold the register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_o <= RESET_STATE;
        else if (load_i)
            state_o <= chan_seed(load_val_i, IDX);
        else if (step_i)
            state_o <= lfsr_next(state_o);
    end

endmodule

// File: rtl/ccip_chan.sv
// One skipper channel: keep/drop decision, drop-run cap and its register.
// Assumes the upstream enable is a level sampled once per clock.
module ccip_chan
    import ccip_pkg::*;
#(
    parameter int                IDX      = 0,
    parameter int                MAX_RUN  = 15,
    parameter logic [LFSR_W-1:0] FALLBACK = SEED_FALLBACK
) (
    input  logic              clk,
    input  logic              rst_n,
    input  chan_cfg_t         cfg_i,
    input  logic              load_i,
    input  logic [LFSR_W-1:0] load_val_i,
    input  logic              en_i,
    output logic              en_o
);

    localparam int RUN_W = $clog2(MAX_RUN + 1);
    localparam logic [RUN_W-1:0] RUN_CAP = RUN_W'(MAX_RUN);

    logic [LFSR_W-1:0] state;
    logic [RUN_W-1:0]  run_q;
    logic              keep;
    logic              step;

    // Advance the register only on active, enabled cycles.
    always_comb step = en_i && cfg_i.on && !load_i;

    ccip_lfsr #(
        .IDX      (IDX),
        .FALLBACK (FALLBACK)
    ) u_lfsr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load_i),
        .load_val_i (load_val_i),
        .step_i     (step),
        .state_o    (state)
    );

    // Keep decision: random threshold, or forced after a full run of drops.
    always_comb begin
        keep = (state[LFSR_W-1 -: LVL_W] <= cfg_i.level) || (run_q == RUN_CAP);
        en_o = en_i && (!cfg_i.on || keep);
    end

    // Count consecutive dropped pulses.
    always_ff @(posedge clk) begin
        if (!rst_n)
            run_q <= '0;
        else if (load_i || !cfg_i.on)
            run_q <= '0;
        else if (en_i)
            run_q <= keep ? '0 : run_q + 1'b1;
    end

endmodule

// File: rtl/clk_cipher_gate.sv
// Top of the clock-cipher pulse skipper: register bank plus one channel per
// clock domain. Channel 0 serves the top clock, channel 1 the crypto clock.
// Assumes both enable streams are in the clk domain.
module clk_cipher_gate
    import ccip_pkg::*;
#(
    parameter int                MAX_RUN  = 15,
    parameter logic [LFSR_W-1:0] FALLBACK = SEED_FALLBACK
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [LFSR_W-1:0] cfg_wdata,
    input  logic              top_en_i,
    input  logic              crypto_en_i,
    output logic              top_en_o,
    output logic              crypto_en_o
);

    chan_cfg_t [NCH-1:0]    cfg;
    logic                   seed_load;
    logic [LFSR_W-1:0]      seed_val;
    logic [NCH-1:0]         en_in;
    logic [NCH-1:0]         en_out;
    logic [NCH-1:0]         chan_on;
    logic [NCH*LVL_W-1:0]   chan_lvl;

    // Gather the per-domain enables into vectors.
    always_comb begin
        en_in       = {crypto_en_i, top_en_i};
        top_en_o    = en_out[0];
        crypto_en_o = en_out[1];
    end

    ccip_regs #(
        .FALLBACK (FALLBACK)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (cfg_we),
        .wr_addr     (cfg_addr),
        .wr_data     (cfg_wdata),
        .cfg_o       (cfg),
        .seed_load_o (seed_load),
        .seed_val_o  (seed_val)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        // Expose each channel's settings for the checker.
        always_comb begin
            chan_on[i]                 = cfg[i].on;
            chan_lvl[LVL_W*i +: LVL_W] = cfg[i].level;
        end

        ccip_chan #(
            .IDX      (i),
            .MAX_RUN  (MAX_RUN),
            .FALLBACK (FALLBACK)
        ) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .cfg_i      (cfg[i]),
            .load_i     (seed_load),
            .load_val_i (seed_val),
            .en_i       (en_in[i]),
            .en_o       (en_out[i])
        );
    end

endmodule

// File: rtl/ccip_chk.sv
// Property checker for clk_cipher_gate, attached by bind. Keeps its own
// count of consecutive drops per channel to check the run cap.
module ccip_chk #(
    parameter int NCH     = 2,
    parameter int LVL_W   = 4,
    parameter int MAX_RUN = 15
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NCH-1:0]       en_in,
    input logic [NCH-1:0]       en_out,
    input logic [NCH-1:0]       chan_on,
    input logic [NCH*LVL_W-1:0] chan_lvl,
    input logic                 seed_load
);

    localparam int CW = $clog2(MAX_RUN + 2) + 1;

    for (genvar i = 0; i < NCH; i++) begin : g_chk
        logic [CW-1:0] drops;

        // Independent count of dropped pulses since the last keep.
        always_ff @(posedge clk) begin
            if (!rst_n)
                drops <= '0;
            else if (seed_load || !chan_on[i])
                drops <= '0;
            else if (en_in[i])
                drops <= en_out[i] ? '0 : ((drops == '1) ? drops : drops + 1'b1);
        end

        a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
            !en_in[i] |-> !en_out[i]);

        a_r2_bypass: assert property (@(posedge clk) disable iff (!rst_n)
            !chan_on[i] |-> (en_out[i] == en_in[i]));

        a_r5_full_speed: assert property (@(posedge clk) disable iff (!rst_n)
            (chan_on[i] && (chan_lvl[LVL_W*i +: LVL_W] == '1)) |-> (en_out[i] == en_in[i]));

        a_r6_forced_keep: assert property (@(posedge clk) disable iff (!rst_n)
            (chan_on[i] && en_in[i] && (drops == CW'(MAX_RUN))) |-> en_out[i]);

        a_r6_run_bound: assert property (@(posedge clk) disable iff (!rst_n)
            drops <= CW'(MAX_RUN));
    end

endmodule

bind clk_cipher_gate ccip_chk #(
    .NCH     (ccip_pkg::NCH),
    .LVL_W   (ccip_pkg::LVL_W),
    .MAX_RUN (MAX_RUN)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_in     (en_in),
    .en_out    (en_out),
    .chan_on   (chan_on),
    .chan_lvl  (chan_lvl),
    .seed_load (seed_load)
);

// File: tb/clk_cipher_gate_tb.sv
// Self-checking bench: a cycle-exact arithmetic copy of both channels,
// driven through sweeps of every level, seed staging and activation.
module clk_cipher_gate_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        top_en_i = 1'b0;
    logic        crypto_en_i = 1'b0;
    logic        top_en_o;
    logic        crypto_en_o;

    int checks = 0;
    int fails  = 0;

    // Bench copy of the state described by the requirements.
    logic [31:0] m_s   [2];
    int          m_run [2];
    bit          m_on  [2];
    int          m_lvl [2];
    logic [31:0] m_seed;
    int          max_run [2];
    int          cur_run [2];
    int          kept [2];

    always #(CLK_PERIOD/2) clk = ~clk;

    clk_cipher_gate u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we      (cfg_we),
        .cfg_addr    (cfg_addr),
        .cfg_wdata   (cfg_wdata),
        .top_en_i    (top_en_i),
        .crypto_en_i (crypto_en_i),
        .top_en_o    (top_en_o),
        .crypto_en_o (crypto_en_o)
    );

    function automatic logic [31:0] swap_halves(input logic [31:0] v);
        return {v[15:0], v[31:16]};
    endfunction

    function automatic logic [31:0] shift1(input logic [31:0] s);
        logic fb;
        fb = s[31] ^ s[21] ^ s[1] ^ s[0];
        return (s << 1) | {31'd0, fb};
    endfunction

    task automatic check(input string req, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0b expected %0b at %0t", req, got, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_s[0] = 32'h1D87_2B41;
        m_s[1] = swap_halves(32'h1D87_2B41);
        m_seed = '0;
        for (int c = 0; c < 2; c++) begin
            m_run[c] = 0; m_on[c] = 0; m_lvl[c] = 0;
            max_run[c] = 0; cur_run[c] = 0; kept[c] = 0;
        end
    endtask

    function automatic bit model_out(input int c, input bit inp);
        if (!inp) return 0;
        if (!m_on[c]) return 1;
        return (int'(m_s[c][31:28]) <= m_lvl[c]) || (m_run[c] == 15);
    endfunction

    // One cycle: drive at negedge, compare, then advance the copy at posedge.
    task automatic cycle(input bit a, input bit b, input bit we,
                         input logic [1:0] adr, input logic [31:0] dat,
                         input string req);
        bit e0, e1, load, ins[2], outs[2];
        top_en_i = a; crypto_en_i = b;
        cfg_we = we; cfg_addr = adr; cfg_wdata = dat;
        #1;
        e0 = model_out(0, a);
        e1 = model_out(1, b);
        check({req, " top"}, top_en_o, e0);
        check({req, " crypto"}, crypto_en_o, e1);
        ins[0] = a; ins[1] = b; outs[0] = top_en_o; outs[1] = crypto_en_o;
        @(posedge clk);
        load = we && adr == 2'd2 && dat == 32'h0000_005A;
        for (int c = 0; c < 2; c++) begin
            if (m_on[c] && ins[c]) begin
                if (outs[c]) begin kept[c]++; cur_run[c] = 0; end
                else begin cur_run[c]++; if (cur_run[c] > max_run[c]) max_run[c] = cur_run[c]; end
            end
            if (load || !m_on[c]) begin
                m_run[c] = 0; cur_run[c] = 0;
            end else if (ins[c]) begin
                m_run[c] = model_out(c, 1) ? 0 : m_run[c] + 1;
            end
            if (load) begin
                m_s[c] = (m_seed == 0) ? 32'h1D87_2B41 : m_seed;
                if (c == 1) m_s[c] = swap_halves(m_s[c]);
            end else if (m_on[c] && ins[c]) begin
                m_s[c] = shift1(m_s[c]);
            end
        end
        if (we && adr == 2'd1) m_seed = dat;
        if (we && adr == 2'd0) begin
            m_lvl[0] = int'(dat[3:0]);  m_on[0] = dat[4];
            m_lvl[1] = int'(dat[11:8]); m_on[1] = dat[12];
        end
        @(negedge clk);
    endtask

    task automatic run_random(input int n, input int pct, input string req);
        for (int k = 0; k < n; k++)
            cycle($urandom_range(99) < pct, $urandom_range(99) < pct, 0, 2'd0, 32'd0, req);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin : stimulus
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: in reset, both channels bypass.
        top_en_i = 1; crypto_en_i = 1; #1;
        check("R1 reset top", top_en_o, 1'b1);
        check("R1 reset crypto", crypto_en_o, 1'b1);
        @(negedge clk);
        rst_n = 1;

        // R2: disabled channels are transparent to random patterns.
        run_random(60, 50, "R2 bypass");

        // R3, R11: enable only the top channel at level 3.
        cycle(1, 1, 1, 2'd0, 32'h0000_0013, "R3 ctrl write");
        run_random(120, 80, "R3 R11 top only");
        // R3, R11: enable only the crypto channel at level 0xA.
        cycle(1, 1, 1, 2'd0, 32'h0000_1A00, "R3 ctrl write");
        run_random(120, 80, "R3 R11 crypto only");

        // R4 R5 R6 R7: sweep every level on both channels.
        for (int lv = 0; lv < 16; lv++) begin
            logic [31:0] w;
            w = 32'h10 | 32'(lv);
            cycle(0, 0, 1, 2'd0, w | (w << 8), "R4 ctrl write");
            for (int c = 0; c < 2; c++) begin kept[c] = 0; max_run[c] = 0; cur_run[c] = 0; end
            for (int k = 0; k < 256; k++)
                cycle(1, ($urandom_range(3) != 0), 0, 2'd0, 32'd0, "R4 R7 level sweep");
            if (lv == 15) begin
                checks++;
                if (kept[0] != 256) begin
                    fails++;
                    $display("FAIL R5: got %0d kept expected 256", kept[0]);
                end
            end
            for (int c = 0; c < 2; c++) begin
                checks++;
                if (max_run[c] > 15 || (lv == 0 && c == 0 && max_run[c] != 15)) begin
                    fails++;
                    $display("FAIL R6: got run %0d expected at most 15 (15 at level 0)", max_run[c]);
                end
            end
        end

        // R8: staging seed and near-miss keys leave the sequence alone.
        cycle(1, 1, 1, 2'd0, 32'h0000_1616, "R8 ctrl write");
        cycle(1, 1, 1, 2'd1, 32'hDEAD_BEEF, "R8 seed write");
        run_random(40, 90, "R8 staged only");
        cycle(1, 1, 1, 2'd2, 32'h0000_005B, "R8 wrong key");
        cycle(1, 1, 1, 2'd2, 32'h0000_015A, "R8 wrong key high bits");
        cycle(1, 1, 1, 2'd3, 32'h0000_005A, "R8 key at wrong address");
        run_random(40, 90, "R8 after wrong keys");
        cycle(1, 1, 1, 2'd2, 32'h0000_005A, "R8 activation");
        run_random(150, 90, "R8 R7 after activation");

        // R9: zero seed is replaced by the fallback constant.
        cycle(1, 1, 1, 2'd1, 32'h0000_0000, "R9 zero seed");
        cycle(1, 1, 1, 2'd2, 32'h0000_005A, "R9 activation");
        run_random(150, 90, "R9 fallback sequence");

        // R10: low upstream enable never produces a pulse.
        run_random(80, 20, "R10 sparse input");

        finish_run();
    end

endmodule